// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the control port of a data converter. A host clocks eight-bit command bytes into it over a serial clock and data line. Each command either writes one byte to a configuration register or reads one back. The block holds the filter-high, filter-low and test registers. It turns their fields into control outputs: input polarity, data-read word length, current boost and a 12-bit filter code. It also frames reads of the conversion data register, which is supplied from outside, at 16 or 24 bits according to the word-length setting. It keeps a data-ready flag that a new result sets and a completed data read clears.

The port runs on a system clock. The serial clock and data lines pass through synchronisers, and each rising serial-clock edge shifts in one bit. Bit framing is positional and has no select line. Stray clock edges can therefore leave the port out of step with the host. The host recovers by sending 32 consecutive one bits, which return the port to the start of a command byte. A filter code that would fall outside the legal range is refused, and a sticky error flag records the refusal.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset, a readback of the filter-high register gives 0x01, filter-low gives 0x40 and test gives 0x00. The outputs are then unipolar 0, word24 0, boost 0, filt_code 0x140, code_err 0, test_mode 0, data_ready 0 and sdo 0.
- R2: Bits are taken MSB first on rising sclk edges. In a command byte, bit 3 set means read and clear means write, bits 2..0 are the register select, and bits 7..4 are ignored. Select 010 is filter-high, 011 is filter-low, 100 is test and 101 is data. A write takes its eight data bits next, and the write takes effect on the eighth of them.
- R3: A filter-high write sets unipolar from bit 7, word24 from bit 6 and boost from bit 5. It offers bits 3..0 as filt_code[11:8]. Bit 4 is discarded and always reads back 0, and readback gives {unipolar, word24, boost, 0, filt_code[11:8]}.
- R4: A filter-low write offers its byte as filt_code[7:0], and readback returns filt_code[7:0].
- R5: A write whose resulting 12-bit code would lie outside 19..4000 leaves the code bits unchanged and sets code_err. code_err stays set until reset, while the polarity, word-length and boost bits of a filter-high write still take effect.
- R6: A read of select 101 shifts out sample_data[23:0] when word24 is 1, and sample_data[23:8] when word24 is 0. A register read shifts out 8 bits. Bit k appears on sdo after the k-th rising edge that follows the command byte, and sdo is 0 outside a read.
- R7: A sample_strobe pulse sets data_ready. data_ready clears at the end of a complete data read and does not clear on a register read.
- R8: 32 consecutive one bits on sdi, counted across all framing states, return the port to the first bit of a command byte.
- R9: test_mode is 1 while the test register is nonzero, and writing 0x00 to the test register clears it.
- R10: A write to any other select, including 000, 111 and data, changes no register. A read of select 000, 001, 110 or 111 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| sdi | input | 1 | Serial data in |
| sample_strobe | input | 1 | Pulse marking a new conversion result |
| sample_data | input | 24 | Current conversion result |
| sdo | output | 1 | Serial data out |
| data_ready | output | 1 | New result not yet read |
| unipolar | output | 1 | 1 selects unipolar input range |
| word24 | output | 1 | 1 selects 24-bit data reads |
| boost | output | 1 | Front-end current boost enable |
| filt_code | output | 12 | Active filter code |
| code_err | output | 1 | Sticky flag for a refused filter code |
| test_mode | output | 1 | Test register is nonzero |

## Verification
The hardest condition to reach from the ports is a framing slip that only the run of 32 ones can repair. Idle ones are themselves commands, so the stimulus has to be chosen with care. The bench shifts in three stray bits ending in a zero and then 32 ones. Those ones decode as harmless reads of an unassigned select, and the run completes in the middle of a command byte. A following filter-high read then returns the expected value only if the port realigned. Without the recovery, the port would still be offset by three bits when that read arrives. The code range limits are reached by sweeping the filter-low byte fully under high nibbles 0 and F, which crosses both 18/19 and 4000/4001.

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
  parameter int CODE_MIN    = 19,
  parameter int CODE_MAX    = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        sdi,
  input  logic        sample_strobe,
  input  logic [23:0] sample_data,
  output logic        sdo,
  output logic        data_ready,
  output logic        unipolar,
  output logic        word24,
  output logic        boost,
  output logic [11:0] filt_code,
  output logic        code_err,
  output logic        test_mode
);
  localparam int          SM       = SYNC_STAGES - 1;
  localparam logic [2:0]  SEL_FH   = 3'b010;
  localparam logic [2:0]  SEL_FL   = 3'b011;
  localparam logic [2:0]  SEL_TEST = 3'b100;
  localparam logic [2:0]  SEL_DATA = 3'b101;
  localparam logic [4:0]  ONES_TOP = 5'd31;

  typedef enum logic [1:0] {S_CMD, S_WR, S_RD} st_t;

  logic [SM:0] sck_q, sdi_q;
  logic        sck_d;
  st_t         st;
  logic [4:0]  cnt, last, ones;
  logic [6:0]  sr;
  logic [2:0]  sel;
  logic [23:0] osr;
  logic        rd_data;
  logic [7:0]  treg;
  logic [7:0]  rd_byte;

  wire        rise     = sck_q[SM] & ~sck_d;
  wire        bit_in   = sdi_q[SM];
  wire [7:0]  byte_in  = {sr, bit_in};
  wire        ones_hit = rise & bit_in & (ones == ONES_TOP);
  wire        in_read  = (st == S_RD);
  wire        in_cmd   = (st == S_CMD);
  wire        rd_done  = rise & ~ones_hit & in_read & (cnt == last) & rd_data;
  wire [11:0] cand_hi  = {byte_in[3:0], filt_code[7:0]};
  wire [11:0] cand_lo  = {filt_code[11:8], byte_in};

  function automatic logic legal(input logic [11:0] c);
    return (int'(c) >= CODE_MIN) && (int'(c) <= CODE_MAX);
  endfunction

  assign sdo       = in_read & osr[23];
  assign test_mode = |treg;

  always_comb begin
    case (byte_in[2:0])
      SEL_FH:   rd_byte = {unipolar, word24, boost, 1'b0, filt_code[11:8]};
      SEL_FL:   rd_byte = filt_code[7:0];
      SEL_TEST: rd_byte = treg;
      default:  rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      sdi_q <= '0;
      sck_d <= 1'b0;
    end else begin
      sck_q <= {sck_q[SM-1:0], sclk};
      sdi_q <= {sdi_q[SM-1:0], sdi};
      sck_d <= sck_q[SM];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_CMD;
      cnt       <= '0;
      last      <= '0;
      ones      <= '0;
      sr        <= '0;
      sel       <= '0;
      osr       <= '0;
      rd_data   <= 1'b0;
      unipolar  <= 1'b0;
      word24    <= 1'b0;
      boost     <= 1'b0;
      filt_code <= 12'h140;
      code_err  <= 1'b0;
      treg      <= '0;
    end else if (rise) begin
      ones <= bit_in ? ones + 5'd1 : 5'd0;
      if (ones_hit) begin
        st   <= S_CMD;
        cnt  <= '0;
        ones <= '0;
      end else begin
        case (st)
          S_CMD: begin
            sr  <= byte_in[6:0];
            cnt <= cnt + 5'd1;
            if (cnt == 5'd7) begin
              cnt <= '0;
              sel <= byte_in[2:0];
              if (byte_in[3]) begin
                st <= S_RD;
                if (byte_in[2:0] == SEL_DATA) begin
                  osr     <= sample_data;
                  last    <= word24 ? 5'd23 : 5'd15;
                  rd_data <= 1'b1;
                end else begin
                  osr     <= {rd_byte, 16'h0000};
                  last    <= 5'd7;
                  rd_data <= 1'b0;
                end
              end else begin
                st <= S_WR;
              end
            end
          end
          S_WR: begin
            sr  <= byte_in[6:0];
            cnt <= cnt + 5'd1;
            if (cnt == 5'd7) begin
              cnt <= '0;
              st  <= S_CMD;
              case (sel)
                SEL_FH: begin
                  unipolar <= byte_in[7];
                  word24   <= byte_in[6];
                  boost    <= byte_in[5];
                  if (legal(cand_hi)) filt_code[11:8] <= byte_in[3:0];
                  else                code_err        <= 1'b1;
                end
                SEL_FL: begin
                  if (legal(cand_lo)) filt_code[7:0] <= byte_in;
                  else                code_err       <= 1'b1;
                end
                SEL_TEST: treg <= byte_in;
                default: ;
              endcase
            end
          end
          default: begin
            osr <= {osr[22:0], 1'b0};
            cnt <= cnt + 5'd1;
            if (cnt == last) begin
              cnt <= '0;
              st  <= S_CMD;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             data_ready <= 1'b0;
    else if (sample_strobe) data_ready <= 1'b1;
    else if (rd_done)       data_ready <= 1'b0;
  end
endmodule

module cfg_serial_port_chk #(
  parameter int CODE_MIN = 19,
  parameter int CODE_MAX = 4000
) (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] filt_code,
  input logic        code_err,
  input logic        data_ready,
  input logic        sample_strobe,
  input logic        sdo,
  input logic        in_read,
  input logic        in_cmd,
  input logic        ones_hit,
  input logic [4:0]  cnt
);
  p_code_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(filt_code) >= CODE_MIN) && (int'(filt_code) <= CODE_MAX));

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |=> code_err);

  p_code_held_on_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_err) |-> $stable(filt_code));

  p_ready_from_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(sample_strobe));

  p_ready_clears_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_ready) |-> $past(in_read));

  p_sdo_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_read |-> !sdo);

  p_ones_realign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ones_hit |=> (in_cmd && cnt == 5'd0));
endmodule

bind cfg_serial_port cfg_serial_port_chk #(.CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .filt_code(filt_code), .code_err(code_err),
  .data_ready(data_ready), .sample_strobe(sample_strobe), .sdo(sdo),
  .in_read(in_read), .in_cmd(in_cmd), .ones_hit(ones_hit), .cnt(cnt)
);

// File: tb/sim_cfg_serial_port.sv
module sim_cfg_serial_port;
  logic        clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic        sample_strobe = 1'b0;
  logic [23:0] sample_data = '0;
  logic        sdo, data_ready, unipolar, word24, boost, code_err, test_mode;
  logic [11:0] filt_code;

  int nchk = 0, nfail = 0;
  bit done = 0;

  logic        m_uni = 0, m_wl = 0, m_bst = 0, m_err = 0;
  logic [11:0] m_code = 12'h140;
  logic [7:0]  m_treg = 8'h00;

  cfg_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi),
    .sample_strobe(sample_strobe), .sample_data(sample_data),
    .sdo(sdo), .data_ready(data_ready), .unipolar(unipolar), .word24(word24),
    .boost(boost), .filt_code(filt_code), .code_err(code_err), .test_mode(test_mode)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bitx(input logic b, output logic s);
    sdi = b;
    repeat (4) @(negedge clk);
    s = sdo;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) bitx(v[i], s);
  endtask

  task automatic read_n(input int n, output logic [23:0] v);
    logic s;
    v = '0;
    for (int k = 0; k < n; k++) begin
      bitx(1'b0, s);
      v = {v[22:0], s};
    end
  endtask

  function automatic logic ok_code(input logic [11:0] c);
    return (c >= 12'd19) && (c <= 12'd4000);
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [7:0] b);
    send_byte({5'b00000, sel});
    send_byte(b);
    case (sel)
      3'b010: begin
        m_uni = b[7]; m_wl = b[6]; m_bst = b[5];
        if (ok_code({b[3:0], m_code[7:0]})) m_code[11:8] = b[3:0];
        else m_err = 1'b1;
      end
      3'b011: begin
        if (ok_code({m_code[11:8], b})) m_code[7:0] = b;
        else m_err = 1'b1;
      end
      3'b100: m_treg = b;
      default: ;
    endcase
  endtask

  task automatic rd_reg(input logic [2:0] sel, output logic [7:0] v);
    logic [23:0] t;
    send_byte({5'b00001, sel});
    read_n(8, t);
    v = t[7:0];
  endtask

  function automatic logic [7:0] fh_exp();
    return {m_uni, m_wl, m_bst, 1'b0, m_code[11:8]};
  endfunction

  task automatic chk_outs(input string req);
    chk(req, {7'd0, unipolar, word24, boost, filt_code, code_err, test_mode},
             {7'd0, m_uni, m_wl, m_bst, m_code, m_err, (m_treg != 8'h00)});
  endtask

  task automatic strobe(input logic [23:0] d);
    @(negedge clk);
    sample_data = d;
    sample_strobe = 1'b1;
    @(negedge clk);
    sample_strobe = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    logic [7:0]  v;
    logic [23:0] w;
    logic        s;
    logic [23:0] pats [4];
    pats[0] = 24'hA5C3E1; pats[1] = 24'h000001; pats[2] = 24'hFFFFFE; pats[3] = 24'h3C5A96;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R1 outputs", {unipolar, word24, boost, filt_code, code_err, test_mode, data_ready, sdo},
                      {3'b000, 12'h140, 4'b0000});
    rd_reg(3'b010, v); chk("R1 filter-high reset", v, 8'h01);
    rd_reg(3'b011, v); chk("R1 filter-low reset", v, 8'h40);
    rd_reg(3'b100, v); chk("R1 test reset", v, 8'h00);

    // R4 and R5: full low-byte sweep descending under high nibble 0 (crosses 19/18)
    wr(3'b011, 8'h80);
    wr(3'b010, 8'h00);
    chk_outs("R3 high nibble zero");
    for (int i = 255; i >= 0; i--) begin
      wr(3'b011, 8'(i));
      chk_outs("R4 R5 low sweep hi0");
    end
    rd_reg(3'b011, v); chk("R4 low readback", v, m_code[7:0]);
    wr(3'b010, 8'h0F);
    chk_outs("R5 high nibble F");
    // low-byte sweep under high nibble F (crosses 4000/4001)
    for (int i = 0; i < 256; i++) begin
      wr(3'b011, 8'(i));
      chk_outs("R4 R5 low sweep hiF");
    end
    chk("R5 sticky error", {23'd0, code_err}, 24'd1);

    // R3: every filter-high byte, fields and readback
    for (int i = 0; i < 256; i++) begin
      wr(3'b010, 8'(i));
      chk_outs("R3 high sweep outputs");
      rd_reg(3'b010, v);
      chk("R3 high sweep readback", v, fh_exp());
    end

    // R6 and R7: data reads in both word lengths
    for (int lw = 1; lw >= 0; lw--) begin
      wr(3'b010, lw[0] ? 8'h4A : 8'h0A);
      chk_outs("R6 word length set");
      for (int p = 0; p < 4; p++) begin
        strobe(pats[p]);
        chk("R7 ready after strobe", {23'd0, data_ready}, 24'd1);
        rd_reg(3'b010, v);
        chk("R7 register read keeps ready", {23'd0, data_ready}, 24'd1);
        send_byte(8'h0D);
        read_n(lw[0] ? 24 : 16, w);
        chk("R6 data read", w, lw[0] ? pats[p] : {8'h00, pats[p][23:8]});
        chk("R7 ready cleared", {23'd0, data_ready}, 24'd0);
        chk("R6 sdo idle", {23'd0, sdo}, 24'd0);
      end
    end

    // R9: test register
    wr(3'b100, 8'h5A);
    chk_outs("R9 test nonzero");
    rd_reg(3'b100, v); chk("R9 test readback", v, 8'h5A);
    wr(3'b100, 8'h80);
    chk("R9 test top bit", {23'd0, test_mode}, 24'd1);
    wr(3'b100, 8'h00);
    chk_outs("R9 test cleared");

    // R10: unassigned and data-register writes are ignored
    wr(3'b000, 8'hFF);
    wr(3'b111, 8'h00);
    wr(3'b101, 8'hFF);
    chk_outs("R10 ignored writes");
    rd_reg(3'b010, v); chk("R10 filter-high intact", v, fh_exp());
    rd_reg(3'b011, v); chk("R10 filter-low intact", v, m_code[7:0]);
    rd_reg(3'b000, v); chk("R10 read select 000", v, 8'h00);
    rd_reg(3'b111, v); chk("R10 read select 111", v, 8'h00);
    rd_reg(3'b001, v); chk("R10 read select 001", v, 8'h00);

    // R8: slip by three bits, then 32 ones realign the framing
    bitx(1'b1, s); bitx(1'b1, s); bitx(1'b0, s);
    for (int i = 0; i < 32; i++) bitx(1'b1, s);
    rd_reg(3'b010, v); chk("R8 realigned read", v, fh_exp());
    chk_outs("R8 no register change");
    // R2: bits 7..4 of a command are ignored
    send_byte(8'hF0 | 8'h0B);
    read_n(8, w); chk("R2 upper command bits ignored", w, {16'h0, m_code[7:0]});

    finish_run();
  end
endmodule